// File: doc/BRIEF.md
# Glitch-Free Clock Stop Gate

This block switches a group of derived clock outputs off and on without ever producing a shortened pulse. A single stop request, active low and asynchronous to everything, is brought into the domain of the clock being gated. When it takes effect, every stoppable output parks at logic 0. When the request is withdrawn, the outputs come back starting with a complete high phase. One or more outputs can be marked as free-running. These outputs ignore the stop request but still obey their own enable bit. A per-output mask holds any output low while its bit is 0.

The same design serves groups with different needs through parameters: the group width, which outputs are free-running, the synchronizer depth that sets both latencies, and a minimum run time. After a restart, a stop may not cut the outputs off until that many high pulses have been produced. A stop request that arrives inside this window is remembered and applied when the window closes, even if it has already been released. The design instantiates the block once per clock group, each time with the source clock of that group.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_i` is high, every `gclk_o` bit is held at 0. The first high phase after reset is driven by the rising edge that follows the first falling edge seeing `rst_i` low.
- R2: `stop_n_i` goes through SYNC_STAGES flip-flops on `clk_i`. If it is first sampled low at rising edge k, stoppable outputs still pulse at edges k..k+SYNC_STAGES and stay low from edge k+SYNC_STAGES+1, provided the run window has elapsed.
- R3: Every output is 0 throughout each low phase of `clk_i`. Each high phase of an output is a complete high phase of `clk_i`, so no runt pulse occurs.
- R4: If `stop_n_i` is first sampled high at rising edge k while stopped, the first high phase of a stoppable output begins at edge k+SYNC_STAGES+1 and has full width.
- R5: An output whose FREE_MASK bit is 1 ignores `stop_n_i` entirely and pulses on every cycle its mask bit allows.
- R6: An output whose `mask_i` bit is 0 stays low and does not switch. A mask value captured at a falling edge of `clk_i` governs the high phase that begins at the next rising edge.
- R7: After a restart, the stoppable outputs produce at least MIN_RUN high pulses before a stop takes effect.
- R8: A stop request observed during the run window is held pending. It stops the outputs when the window closes, even if `stop_n_i` has returned high. The outputs then miss one pulse and resume.
- R9: Reset leaves the run window already elapsed, so a stop requested right after reset takes effect with only the R2 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock of the group; also clocks the control logic |
| rst_i | input | 1 | Synchronous active-high reset |
| stop_n_i | input | 1 | Asynchronous active-low stop request |
| mask_i | input | WIDTH | Per-output enable, 1 = output allowed to run |
| gclk_o | output | WIDTH | Gated clock outputs |

## Verification
The hardest situation to reach is a stop that is pending. The request has to reach the control logic inside the run window and must be gone again before the window closes. Only then does the remembered request, and not the live level, decide the stop. The stimulus waits for the first restarted pulse and then drops `stop_n_i` for a single cycle. It counts the pulses up to the first missing one and expects exactly MIN_RUN, followed by an immediate resume. The window itself is checked the same way, with the request held low from the first restarted pulse onward.

// File: rtl/csg_pkg.sv
package csg_pkg;

    typedef enum logic {
        GATE_RUN  = 1'b0,
        GATE_HALT = 1'b1
    } gate_state_e;

    typedef struct packed {
        gate_state_e st;
        logic        pend;
    } gate_ctl_t;

    // Saturating increment on plain integers; callers cast to their width.
    function automatic int sat_step(input int v, input int lim);
        return (v >= lim) ? lim : v + 1;
    endfunction

    function automatic int cnt_width(input int lim);
        return (lim < 2) ? 1 : $clog2(lim + 1);
    endfunction

endpackage

// File: rtl/csg_sync.sv
module csg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_n_i,
    output logic sync_n_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= '1;
        else       chain_q <= {chain_q[STAGES-2:0], async_n_i};
    end

    assign sync_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/csg_ctrl.sv
module csg_ctrl
    import csg_pkg::*;
#(
    parameter int MIN_RUN = 100
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic stop_req_i,
    output logic run_o
);
    localparam int                CNT_W   = cnt_width(MIN_RUN);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_RUN);
    localparam logic [CNT_W-1:0] DONE_AT = CNT_W'(MIN_RUN - 1);

    gate_ctl_t        ctl_q, ctl_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             window_done;

    assign window_done = (cnt_q >= DONE_AT);

    always_comb begin
        ctl_d = ctl_q;
        cnt_d = cnt_q;
        unique case (ctl_q.st)
            GATE_RUN: begin
                cnt_d = CNT_W'(sat_step(int'(cnt_q), MIN_RUN));
                if (window_done) begin
                    if (stop_req_i || ctl_q.pend) begin
                        ctl_d.st   = GATE_HALT;
                        ctl_d.pend = 1'b0;
                    end
                end else if (stop_req_i) begin
                    ctl_d.pend = 1'b1;
                end
            end
            GATE_HALT: begin
                if (!stop_req_i) begin
                    ctl_d.st = GATE_RUN;
                    cnt_d    = '0;
                end
            end
            default: ctl_d = ctl_q;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q <= '{st: GATE_RUN, pend: 1'b0};
            cnt_q <= CNT_MAX;
        end else begin
            ctl_q <= ctl_d;
            cnt_q <= cnt_d;
        end
    end

    assign run_o = (ctl_q.st == GATE_RUN);
endmodule

// File: rtl/csg_gate.sv
module csg_gate #(
    parameter int               WIDTH     = 4,
    parameter logic [WIDTH-1:0] FREE_MASK = '0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_i,
    input  logic [WIDTH-1:0] mask_i,
    output logic [WIDTH-1:0] en_o,
    output logic [WIDTH-1:0] gclk_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        logic en_d, en_q;

        if (FREE_MASK[i]) begin : g_free
            assign en_d = mask_i[i];
        end else begin : g_stop
            assign en_d = mask_i[i] & run_i;
        end

        // Enable moves only on the falling edge, so it is stable across high phases.
        always_ff @(negedge clk_i) begin
            if (rst_i) en_q <= 1'b0;
            else       en_q <= en_d;
        end

        assign en_o[i]   = en_q;
        assign gclk_o[i] = clk_i & en_q;
    end
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
    import csg_pkg::*;
#(
    parameter int               WIDTH       = 4,
    parameter logic [WIDTH-1:0] FREE_MASK   = WIDTH'(1),
    parameter int               SYNC_STAGES = 2,
    parameter int               MIN_RUN     = 100
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             stop_n_i,
    input  logic [WIDTH-1:0] mask_i,
    output logic [WIDTH-1:0] gclk_o
);
    logic             sync_n_w;
    logic             run_w;
    logic [WIDTH-1:0] en_w;

    csg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .async_n_i (stop_n_i),
        .sync_n_o  (sync_n_w)
    );

    csg_ctrl #(.MIN_RUN(MIN_RUN)) u_ctrl (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .stop_req_i (~sync_n_w),
        .run_o      (run_w)
    );

    csg_gate #(.WIDTH(WIDTH), .FREE_MASK(FREE_MASK)) u_gate (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .run_i  (run_w),
        .mask_i (mask_i),
        .en_o   (en_w),
        .gclk_o (gclk_o)
    );
endmodule

// File: rtl/csg_checker.sv
module csg_checker
    import csg_pkg::*;
#(
    parameter int               WIDTH     = 4,
    parameter logic [WIDTH-1:0] FREE_MASK = WIDTH'(1),
    parameter int               MIN_RUN   = 100
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic [WIDTH-1:0] mask_i,
    input logic [WIDTH-1:0] gclk_o,
    input logic             run_w,
    input logic             sync_n_w,
    input logic [WIDTH-1:0] en_w
);
    localparam int CNT_W = cnt_width(MIN_RUN);

    logic [CNT_W-1:0] run_cnt;
    logic             run_prev;
    logic             restarted;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_cnt   <= '0;
            run_prev  <= 1'b1;
            restarted <= 1'b0;
        end else begin
            run_cnt   <= run_w ? CNT_W'(sat_step(int'(run_cnt), MIN_RUN)) : '0;
            run_prev  <= run_w;
            restarted <= restarted | (run_w & ~run_prev);
        end
    end

    AST_LOW_BEFORE_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
        gclk_o == '0);                                                              // R3

    AST_RESTART_AFTER_RELEASE: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(run_w) |-> $past(sync_n_w));                                          // R4

    AST_FREE_FOLLOWS_MASK: assert property (@(negedge clk_i) disable iff (rst_i)
        1'b1 |=> ($past(rst_i) || ((en_w & FREE_MASK) == ($past(mask_i) & FREE_MASK)))); // R5

    AST_MASKED_HELD_LOW: assert property (@(negedge clk_i) disable iff (rst_i)
        1'b1 |=> ((en_w & ~$past(mask_i)) == '0));                                  // R6

    AST_MIN_RUN_WINDOW: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(run_w) && restarted) |-> (int'(run_cnt) >= MIN_RUN));                // R7
endmodule

bind clk_stop_gate csg_checker #(
    .WIDTH     (WIDTH),
    .FREE_MASK (FREE_MASK),
    .MIN_RUN   (MIN_RUN)
) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .mask_i   (mask_i),
    .gclk_o   (gclk_o),
    .run_w    (run_w),
    .sync_n_w (sync_n_w),
    .en_w     (en_w)
);

// File: tb/clk_stop_gate_tb.sv
`timescale 1ns/1ps
module clk_stop_gate_tb;
    localparam int           W    = 4;
    localparam logic [W-1:0] FREE = 4'b0001;
    localparam int           S    = 2;
    localparam int           MR   = 12;

    logic         clk = 1'b0;
    logic         rst_i = 1'b1;
    logic         stop_n_i = 1'b1;
    logic [W-1:0] mask_i = '1;
    logic [W-1:0] gclk_o;

    always #2.5 clk = ~clk;

    clk_stop_gate #(.WIDTH(W), .FREE_MASK(FREE), .SYNC_STAGES(S), .MIN_RUN(MR)) u_dut (
        .clk_i(clk), .rst_i(rst_i), .stop_n_i(stop_n_i), .mask_i(mask_i), .gclk_o(gclk_o)
    );

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    bit           q[$];
    bit           m_running;
    int           m_elapsed;
    bit           m_pend;
    logic [W-1:0] exp_en = '0;
    string        exp_tag[W];
    bit           armed = 0;
    logic [W-1:0] hi;

    logic         nxt_rst = 1'b1;
    logic         nxt_stop = 1'b1;
    logic [W-1:0] nxt_mask = '1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit s;
        if (rst_i) begin
            q = {};
            for (int k = 0; k < S; k++) q.push_back(1'b1);
            m_running = 1; m_elapsed = MR; m_pend = 0;
        end else begin
            s = q.pop_front();
            q.push_back(stop_n_i);
            if (m_running) begin
                if (m_elapsed < MR) m_elapsed++;
                if (m_elapsed >= MR) begin
                    if (!s || m_pend) begin m_running = 0; m_pend = 0; end
                end else if (!s) m_pend = 1;
            end else if (s) begin
                m_running = 1; m_elapsed = 0;
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        hi = gclk_o;
        if (armed)
            for (int i = 0; i < W; i++)
                check(hi[i] === exp_en[i], exp_tag[i], $sformatf("high phase bit %0d", i),
                      int'(hi[i]), int'(exp_en[i]));
        model_edge();
        rst_i = nxt_rst; stop_n_i = nxt_stop; mask_i = nxt_mask;
        for (int i = 0; i < W; i++) begin
            exp_en[i] = !nxt_rst && nxt_mask[i] && (m_running || FREE[i]);
            exp_tag[i] = nxt_rst ? "R1" : FREE[i] ? "R5" : !nxt_mask[i] ? "R6" : "R4";
        end
        #2;
        if (armed) check(gclk_o === '0, "R3", "low phase", int'(gclk_o), 0);
        armed = 1;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int n;
        for (int k = 0; k < 4; k++) step();
        check(hi === '0, "R1", "outputs during reset", int'(hi), 0);
        nxt_rst = 0; step();
        step();
        check(hi === '1, "R1", "first pulse after reset", int'(hi), 15);

        // R9 + R2: stop right after reset, window already elapsed
        nxt_stop = 0; step();
        n = 0;
        for (int k = 0; k < 8; k++) begin step(); n += hi[1]; end
        check(n == S + 1, "R2", "pulses after stop (R9)", n, S + 1);

        // R4: release and measure restart latency
        nxt_stop = 1; step();
        n = 0;
        for (int k = 0; k < 20 && !hi[1]; k++) begin step(); n++; end
        check(n == S + 2, "R4", "edges to first restarted pulse", n, S + 2);

        // R7: stop asserted from first restarted pulse; count run length
        nxt_stop = 0;
        n = 1;
        for (int k = 0; k < 4 * MR && hi[1]; k++) begin step(); n += hi[1]; end
        check(n == MR, "R7", "pulses before window stop", n, MR);

        // R8: one-cycle stop pulse inside window
        nxt_stop = 1; step();
        for (int k = 0; k < 20 && !hi[1]; k++) step();
        nxt_stop = 0; step(); nxt_stop = 1;
        n = 1 + hi[1];
        for (int k = 0; k < 4 * MR && hi[1]; k++) begin step(); n += hi[1]; end
        check(n == MR, "R8", "pulses before pending stop", n, MR);
        step();
        check(hi[1] == 1'b1, "R8", "resume after pending stop", int'(hi[1]), 1);

        // R6: mask off a stoppable output while running
        for (int k = 0; k < MR; k++) step();
        nxt_mask = 4'b1011; step();
        n = 0;
        for (int k = 0; k < 6; k++) begin step(); n += hi[2]; end
        check(n == 0, "R6", "masked bit 2 pulses", n, 0);

        // R5 + R6: free output obeys its mask but not the stop request
        nxt_mask = 4'b1111; nxt_stop = 0; step();
        n = 0;
        for (int k = 0; k < 8; k++) begin step(); n += hi[0]; end
        check(n == 8, "R5", "free output pulses while stopped", n, 8);
        nxt_mask = 4'b1110; step();
        n = 0;
        for (int k = 0; k < 6; k++) begin step(); n += hi[0]; end
        check(n == 0, "R6", "masked free output pulses", n, 0);
        nxt_mask = '1; nxt_stop = 1;
        for (int k = 0; k < 10; k++) step();

        // R1: reset while stopped
        nxt_stop = 0;
        for (int k = 0; k < 8; k++) step();
        nxt_rst = 1; step(); step();
        check(hi === '0, "R1", "outputs in mid-run reset", int'(hi), 0);
        nxt_rst = 0; nxt_stop = 1;
        for (int k = 0; k < 6; k++) step();
        check(hi === '1, "R1", "outputs after second reset", int'(hi), 15);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule